// File: doc/BRIEF.md
# Supply Lockout Write-Inhibit Sequencer

This block sits in front of the write path of a nonvolatile memory controller. It takes a single-bit supply-good flag from an external voltage comparator and produces a write-inhibit level. It also produces a gated write-start strobe that the controller uses to launch programming cycles. Reads never pass through the block and are never held off.

The raw flag is first brought into the clock domain. It is then deglitched, so a new level counts only after it has held for a set number of cycles. When the filtered flag goes high, a long power-up hold counter begins. Writes are released only after the filtered flag has stayed high for the whole hold window. Any filtered drop during the hold clears the counter, and the window starts again. When the filtered flag falls, the inhibit asserts in the same cycle. This refuses new write starts at once. A programming cycle that was launched earlier is not aborted, because the block only gates the start strobe. Every delay is a parameter counted in clock cycles.

Top module: `supply_lockout_seq`

## Requirements
- R1: While rst_ni is low, wr_inhibit_o is 1 and wr_start_ok_o is 0, whatever wr_start_i and vcc_ok_i do.
- R2: When vcc_ok_i rises from a settled low and stays high, wr_inhibit_o falls exactly SYNC_STAGES+FILT_CYCLES+HOLD_CYCLES clock edges later. It is still 1 one edge earlier.
- R3: When vcc_ok_i falls from a released state and stays low, wr_inhibit_o rises exactly SYNC_STAGES+FILT_CYCLES edges later.
- R4: A pulse on vcc_ok_i shorter than FILT_CYCLES cycles, in either direction, leaves wr_inhibit_o unchanged.
- R5: A low level of FILT_CYCLES cycles or more during the hold window restarts the hold. Release then comes SYNC_STAGES+FILT_CYCLES+HOLD_CYCLES edges after vcc_ok_i rises again.
- R6: A low pulse shorter than FILT_CYCLES during the hold window does not restart it. Release keeps its original timing.
- R7: wr_start_ok_o is 1 exactly when wr_start_i is 1 and wr_inhibit_o is 0. A start request seen while the inhibit is high is refused and produces 0.
- R8: A rising edge of wr_inhibit_o never waits on the hold counter. It happens in the same cycle as the filtered supply flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_ok_i | input | 1 | Raw supply-above-threshold flag from the comparator, asynchronous |
| wr_start_i | input | 1 | Write-start request strobe from the controller |
| wr_inhibit_o | output | 1 | 1 while new writes are locked out |
| wr_start_ok_o | output | 1 | Write-start request passed through when not inhibited |

## Verification
The start gate and the lockout sequencing can change in the same cycle. This happens when a write request arrives on the very edge where the inhibit falls at the end of the hold, or rises after a filtered drop. The bench holds wr_start_i high across both boundaries and samples wr_start_ok_o one edge before and at the computed transition edge. It expects 0 then 1 at release, and 1 then 0 at lockout. The deglitch and the hold restart also overlap: dips one cycle short of and exactly at the filter length are placed inside the hold window, and the release edge is judged against the original rise and the re-rise respectively.

// File: rtl/lockout_pkg.sv
package lockout_pkg;
  typedef enum logic {
    SUPPLY_LOW = 1'b0,
    SUPPLY_OK  = 1'b1
  } supply_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lockout_deglitch.sv
module lockout_deglitch
  import lockout_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    raw_i,
  output supply_e filt_o
);
  localparam int CW = cnt_w(FILT_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  supply_e                filt_q;
  logic                   sync_lvl;

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= raw_i;
      else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= SUPPLY_LOW;
    end else if (sync_lvl != logic'(filt_q)) begin
      if (cnt_q == CW'(FILT_CYCLES-1)) begin
        cnt_q  <= '0;
        filt_q <= supply_e'(sync_lvl);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign filt_o = filt_q;

  // R4
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(cnt_q) == CW'(FILT_CYCLES-1)));
endmodule

// File: rtl/lockout_hold_timer.sv
module lockout_hold_timer
  import lockout_pkg::*;
#(
  parameter int HOLD_CYCLES = 2000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  supply_e filt_i,
  output logic    inhibit_o
);
  localparam int CW = cnt_w(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (filt_i == SUPPLY_LOW)  cnt_q <= '0;
    else if (!done)                 cnt_q <= cnt_q + CW'(1);
  end

  assign done      = (cnt_q == CW'(HOLD_CYCLES));
  assign inhibit_o = !((filt_i == SUPPLY_OK) && done);

  // R5
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_i == SUPPLY_LOW) |=> (cnt_q == '0));

  // R2
  release_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inhibit_o) |-> ($past(cnt_q) == CW'(HOLD_CYCLES-1)));
endmodule

// File: rtl/lockout_start_gate.sv
module lockout_start_gate (
  input  logic wr_start_i,
  input  logic inhibit_i,
  output logic start_ok_o
);
  assign start_ok_o = wr_start_i && !inhibit_i;
endmodule

// File: rtl/supply_lockout_seq.sv
module supply_lockout_seq
  import lockout_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 8,
  parameter int HOLD_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic wr_start_i,
  output logic wr_inhibit_o,
  output logic wr_start_ok_o
);
  supply_e filt_w;
  logic    inhibit_w;

  lockout_deglitch #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) deglitch_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (vcc_ok_i),
    .filt_o (filt_w)
  );

  lockout_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .filt_i    (filt_w),
    .inhibit_o (inhibit_w)
  );

  lockout_start_gate gate_i (
    .wr_start_i (wr_start_i),
    .inhibit_i  (inhibit_w),
    .start_ok_o (wr_start_ok_o)
  );

  assign wr_inhibit_o = inhibit_w;

  // R8
  fast_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_w == SUPPLY_LOW) && $past(filt_w == SUPPLY_OK)) |-> wr_inhibit_o);

  // R7
  start_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inhibit_o && wr_start_i) |-> !wr_start_ok_o);
endmodule

// File: tb/supply_lockout_seq_tb_top.sv
module supply_lockout_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int FILT = 4;
  localparam int HOLD = 40;
  localparam int REL  = SYNC + FILT + HOLD;
  localparam int LCK  = SYNC + FILT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0;
  logic wr_start = 1'b0;
  logic inhibit, start_ok;
  int   n_vec = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_lockout_seq #(
    .SYNC_STAGES(SYNC), .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc_ok),
    .wr_start_i(wr_start), .wr_inhibit_o(inhibit), .wr_start_ok_o(start_ok)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // settle low and locked from any state
  task automatic go_low();
    vcc_ok = 1'b0;
    step(REL + 5);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vcc_ok = 1'b1; wr_start = 1'b1;
    step(3);
    chk("R1 inhibit in reset", inhibit, 1'b1);
    chk("R1 start_ok in reset", start_ok, 1'b0);
    wr_start = 1'b0;
    rst_n = 1'b1;
    go_low();
  endtask

  task automatic t_release();
    vcc_ok = 1'b1; wr_start = 1'b1;
    step(REL - 1);
    chk("R2 still inhibited", inhibit, 1'b1);
    chk("R7 start refused before release", start_ok, 1'b0);
    step(1);
    chk("R2 released", inhibit, 1'b0);
    chk("R7 start passed at release", start_ok, 1'b1);
    wr_start = 1'b0;
    #1;
    chk("R7 no request no start", start_ok, 1'b0);
    wr_start = 1'b1;
  endtask

  task automatic t_drop();
    vcc_ok = 1'b0;
    step(LCK - 1);
    chk("R3 not yet locked", inhibit, 1'b0);
    chk("R7 start passed before lock", start_ok, 1'b1);
    step(1);
    chk("R3 locked", inhibit, 1'b1);
    chk("R7 start refused at lock", start_ok, 1'b0);
    wr_start = 1'b0;
    step(5);
  endtask

  task automatic t_glitch_low();
    bit bad = 1'b0;
    vcc_ok = 1'b1;
    step(REL + 2);
    vcc_ok = 1'b0;
    step(FILT - 1);
    vcc_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (inhibit !== 1'b0) bad = 1'b1;
    end
    chk("R4 low glitch ignored", bad, 1'b0);
    go_low();
  endtask

  task automatic t_glitch_high();
    bit bad = 1'b0;
    vcc_ok = 1'b1;
    step(FILT - 1);
    vcc_ok = 1'b0;
    for (int i = 0; i < REL + 10; i++) begin
      step(1);
      if (inhibit !== 1'b1) bad = 1'b1;
    end
    chk("R4 high glitch ignored", bad, 1'b0);
  endtask

  task automatic t_restart();
    vcc_ok = 1'b1;
    step(20);
    vcc_ok = 1'b0;
    step(FILT);
    vcc_ok = 1'b1;
    step(REL - 1);
    chk("R5 hold restarted, still inhibited", inhibit, 1'b1);
    step(1);
    chk("R5 release after restart", inhibit, 1'b0);
    go_low();
  endtask

  task automatic t_short_dip_in_hold();
    vcc_ok = 1'b1;
    step(20);
    vcc_ok = 1'b0;
    step(FILT - 1);
    vcc_ok = 1'b1;
    step(REL - 1 - 20 - (FILT - 1));
    chk("R6 still inhibited", inhibit, 1'b1);
    step(1);
    chk("R6 release on original time", inhibit, 1'b0);
    go_low();
  endtask

  initial begin
    #1;
    t_reset();
    t_release();
    t_drop();
    t_glitch_low();
    t_glitch_high();
    t_restart();
    t_short_dip_in_hold();
    t_release();
    t_drop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule